// File: doc/BRIEF.md
# External Memory Stretch-Cycle Sequencer

This block produces the bus control timing for a single external data-memory read or write on a multiplexed address/data bus. A request arrives with a direction, a 3-bit stretch selector and a page-hit flag. The block then walks through four phases: an optional address-latch phase, a setup phase, a strobe phase and a hold phase. It finishes with a one-clock completion pulse. Every phase length is counted in system clocks, and one stretch cycle is four system clocks.

The selector maps to stretch cycles in a nonlinear way. Codes 0 through 7 give 0, 1, 2, 3, 7, 8, 9 and 10 stretch cycles. Codes 1 to 3 add one clock of setup and one clock of hold around a wider strobe. Codes 4 to 7 form a slow-peripheral group. In that group, two stretch cycles go to extra setup, one stretch cycle goes to extra hold, and a page miss lengthens the address-latch pulse by one stretch cycle. A page hit skips the address-latch phase entirely. A flat-mode input selects the page arrangement whose basic data cycle is always four clocks; in that mode every access is timed as a miss.

Top module: `xmem_stretch_seq`

## Requirements
- R1: The strobe phase lasts 2 clocks for selector 0 and 4 x selector clocks for selectors 1 to 7 (4, 8, 12, 16, 20, 24, 28). This corresponds to stretch cycles 0,1,2,3,7,8,9,10 less the three margin cycles of the slow group.
- R2: Setup and hold phases last 1 and 1 clocks for selector 0, 2 and 2 clocks for selectors 1 to 3, and 9 and 5 clocks for selectors 4 to 7.
- R3: On a page miss, `ale` is high for 2 clocks (6 clocks for selectors 4 to 7) directly after acceptance. `addr_oe` is high in exactly the same clocks. On a page hit, `ale` never rises and the access starts with setup.
- R4: When `flat_mode` is 1, `page_hit` is ignored and the access is timed as a page miss.
- R5: `rd_n` and `wr_n` are active low. Only the one matching `req_write` (1 = write) goes low, and only during the strobe phase. Both are never low together.
- R6: For a write, `wdata_oe` is high for every clock from the first setup clock to the last hold clock. For a read, it stays low throughout.
- R7: A request is accepted only when idle. Selector, page-hit, flat-mode and direction are captured at acceptance, and a request raised during an access has no effect.
- R8: `done` is high for exactly one clock, in the clock right after the last hold clock. The first clock of a new access begins on the clock after acceptance.
- R9: A synchronous active-high `rst` returns the block to idle in the next clock: `ale`, `addr_oe`, `wdata_oe` and `done` low, `rd_n` and `wr_n` high. It also aborts any access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an access (sampled only when idle) |
| req_write | input | 1 | Access direction, 1 = write, 0 = read |
| stretch_sel | input | 3 | Stretch selector code 0..7 |
| page_hit | input | 1 | Upper address matches the open page |
| flat_mode | input | 1 | Four-clock-basic-cycle page arrangement; forces miss timing |
| ale | output | 1 | Address-latch strobe, active high |
| addr_oe | output | 1 | Drive the address onto the multiplexed bus |
| wdata_oe | output | 1 | Drive write data onto the bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest situations to reach from the ports are a second request arriving partway through an access and a reset landing in the middle of a long slow-group write. Neither occurs when accesses are simply issued one after another. The bench therefore drives a conflicting request, with a different direction, selector and page flag, a few clocks into a running access. It then confirms that the phase lengths and strobe choice stay as first captured and that no further access starts afterwards. It also asserts reset while write data is being driven, and then watches that no strobe or completion follows.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;

    // Width of every phase-length field; holds up to 63 clocks.
    localparam int LEN_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef logic [LEN_W-1:0] len_t;

    // Phase lengths for one access, all in system clocks.
    typedef struct packed {
        len_t ale_len;
        len_t setup_len;
        len_t strobe_len;
        len_t hold_len;
    } plan_t;

    // Nonlinear selector to stretch-cycle mapping: 0,1,2,3,7,8,9,10.
    function automatic int stretch_cycles(input int sel);
        return (sel < 4) ? sel : sel + 3;
    endfunction

    // Selectors 4..7 form the slow-peripheral group.
    function automatic bit slow_group(input int sel);
        return sel >= 4;
    endfunction

endpackage

// File: rtl/xmem_stretch_lut.sv
module xmem_stretch_lut
    import xmem_stretch_pkg::*;
#(
    parameter int SEL_W        = 3,
    parameter int STRETCH_CLKS = 4,
    parameter int BASE_STROBE  = 2,
    parameter int BASE_ALE     = 2
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             page_hit,
    input  logic             flat_mode,
    output plan_t            plan
);
    // Stretch cycles the slow group spends on margins (2 setup + 1 hold).
    localparam int SLOW_MARGIN = 3;

    int  sel_i;
    int  sc;
    bit  slow;
    bit  miss;
    int  ale_i, setup_i, strobe_i, hold_i;

    always_comb begin
        sel_i = int'(sel);
        sc    = stretch_cycles(sel_i);
        slow  = slow_group(sel_i);
        miss  = flat_mode || !page_hit;

        if (sc == 0) begin
            strobe_i = BASE_STROBE;
            setup_i  = 1;
            hold_i   = 1;
        end else if (slow) begin
            strobe_i = STRETCH_CLKS * (sc - SLOW_MARGIN);
            setup_i  = 1 + 2 * STRETCH_CLKS;
            hold_i   = 1 + STRETCH_CLKS;
        end else begin
            strobe_i = STRETCH_CLKS * sc;
            setup_i  = 2;
            hold_i   = 2;
        end

        if (!miss)
            ale_i = 0;
        else if (slow)
            ale_i = BASE_ALE + STRETCH_CLKS;
        else
            ale_i = BASE_ALE;

        plan.ale_len    = LEN_W'(ale_i);
        plan.setup_len  = LEN_W'(setup_i);
        plan.strobe_len = LEN_W'(strobe_i);
        plan.hold_len   = LEN_W'(hold_i);
    end
endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_stretch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   req_write,
    input  plan_t  plan_in,
    output phase_e phase,
    output logic   is_write
);
    plan_t plan_q;
    len_t  cnt;

    function automatic len_t last_of(input len_t n);
        return n - len_t'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            is_write <= 1'b0;
            plan_q   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req) begin
                        plan_q   <= plan_in;
                        is_write <= req_write;
                        if (plan_in.ale_len != '0) begin
                            phase <= PH_ALE;
                            cnt   <= last_of(plan_in.ale_len);
                        end else begin
                            phase <= PH_SETUP;
                            cnt   <= last_of(plan_in.setup_len);
                        end
                    end
                end
                PH_ALE: begin
                    if (cnt != '0) cnt <= cnt - len_t'(1);
                    else begin
                        phase <= PH_SETUP;
                        cnt   <= last_of(plan_q.setup_len);
                    end
                end
                PH_SETUP: begin
                    if (cnt != '0) cnt <= cnt - len_t'(1);
                    else begin
                        phase <= PH_STROBE;
                        cnt   <= last_of(plan_q.strobe_len);
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) cnt <= cnt - len_t'(1);
                    else begin
                        phase <= PH_HOLD;
                        cnt   <= last_of(plan_q.hold_len);
                    end
                end
                PH_HOLD: begin
                    if (cnt != '0) cnt <= cnt - len_t'(1);
                    else phase <= PH_DONE;
                end
                PH_DONE: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmem_bus_decode.sv
module xmem_bus_decode
    import xmem_stretch_pkg::*;
(
    input  phase_e phase,
    input  logic   is_write,
    output logic   ale,
    output logic   addr_oe,
    output logic   wdata_oe,
    output logic   rd_n,
    output logic   wr_n,
    output logic   done
);
    logic in_strobe;
    logic in_window;

    always_comb begin
        in_strobe = (phase == PH_STROBE);
        in_window = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        ale       = (phase == PH_ALE);
        addr_oe   = (phase == PH_ALE);
        wdata_oe  = is_write && in_window;
        rd_n      = !(in_strobe && !is_write);
        wr_n      = !(in_strobe && is_write);
        done      = (phase == PH_DONE);
    end
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
    import xmem_stretch_pkg::*;
#(
    parameter int SEL_W        = 3,
    parameter int STRETCH_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic [SEL_W-1:0] stretch_sel,
    input  logic             page_hit,
    input  logic             flat_mode,
    output logic             ale,
    output logic             addr_oe,
    output logic             wdata_oe,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done
);
    plan_t  plan_now;
    phase_e phase;
    logic   is_write;

    xmem_stretch_lut #(
        .SEL_W        (SEL_W),
        .STRETCH_CLKS (STRETCH_CLKS)
    ) u_lut (
        .sel       (stretch_sel),
        .page_hit  (page_hit),
        .flat_mode (flat_mode),
        .plan      (plan_now)
    );

    xmem_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .plan_in   (plan_now),
        .phase     (phase),
        .is_write  (is_write)
    );

    xmem_bus_decode u_dec (
        .phase    (phase),
        .is_write (is_write),
        .ale      (ale),
        .addr_oe  (addr_oe),
        .wdata_oe (wdata_oe),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done)
    );
endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic wdata_oe,
    input logic rd_n,
    input logic wr_n,
    input logic done
);
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r6_no_wdata_on_read: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !wdata_oe);

    a_r6_wdata_on_write: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> wdata_oe);

    a_r3_latch_before_strobe: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n && !wdata_oe));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_hold: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n && !ale && !wdata_oe));

    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && !ale && !wdata_oe && !done));
endmodule

bind xmem_stretch_seq xmem_stretch_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .wdata_oe (wdata_oe),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .done     (done)
);

// File: tb/tb_xmem_stretch_seq.sv
module tb_xmem_stretch_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       req_write = 1'b0;
    logic [2:0] stretch_sel = 3'd0;
    logic       page_hit = 1'b0;
    logic       flat_mode = 1'b0;
    logic       ale, addr_oe, wdata_oe, rd_n, wr_n, done;

    xmem_stretch_seq dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .stretch_sel(stretch_sel), .page_hit(page_hit), .flat_mode(flat_mode),
        .ale(ale), .addr_oe(addr_oe), .wdata_oe(wdata_oe),
        .rd_n(rd_n), .wr_n(wr_n), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // {sel, hit, flat, write, ale, setup, strobe, hold}
    localparam logic [20:0] VEC [16] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 3'd2, 4'd1, 5'd2,  3'd1},
        {3'd0, 1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 5'd2,  3'd1},
        {3'd1, 1'b0, 1'b0, 1'b1, 3'd2, 4'd2, 5'd4,  3'd2},
        {3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 5'd4,  3'd2},
        {3'd2, 1'b0, 1'b0, 1'b0, 3'd2, 4'd2, 5'd8,  3'd2},
        {3'd2, 1'b1, 1'b0, 1'b1, 3'd0, 4'd2, 5'd8,  3'd2},
        {3'd3, 1'b0, 1'b0, 1'b1, 3'd2, 4'd2, 5'd12, 3'd2},
        {3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 4'd2, 5'd12, 3'd2},
        {3'd4, 1'b0, 1'b0, 1'b0, 3'd6, 4'd9, 5'd16, 3'd5},
        {3'd4, 1'b1, 1'b0, 1'b1, 3'd0, 4'd9, 5'd16, 3'd5},
        {3'd5, 1'b0, 1'b0, 1'b1, 3'd6, 4'd9, 5'd20, 3'd5},
        {3'd5, 1'b1, 1'b1, 1'b1, 3'd6, 4'd9, 5'd20, 3'd5},
        {3'd6, 1'b0, 1'b0, 1'b0, 3'd6, 4'd9, 5'd24, 3'd5},
        {3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 4'd9, 5'd24, 3'd5},
        {3'd7, 1'b0, 1'b0, 1'b1, 3'd6, 4'd9, 5'd28, 3'd5},
        {3'd7, 1'b1, 1'b1, 1'b0, 3'd6, 4'd9, 5'd28, 3'd5}
    };

    // Measured figures of the last access.
    int m_ale, m_setup, m_rd, m_wr, m_hold, m_woe, m_both, m_addr_mis, m_len, m_done2;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Issue one access and measure it; a conflicting request is raised at clock inj (0 = none).
    task automatic run_access(input logic [2:0] s, input bit h, input bit f,
                              input bit w, input int inj);
        bit seen;
        @(negedge clk);
        stretch_sel = s; page_hit = h; flat_mode = f; req_write = w; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        m_ale = 0; m_setup = 0; m_rd = 0; m_wr = 0; m_hold = 0; m_woe = 0;
        m_both = 0; m_addr_mis = 0; m_len = 0; m_done2 = 0; seen = 0;
        for (int k = 1; k < 300; k++) begin
            if (inj != 0 && k == inj) begin
                req = 1'b1; req_write = !w; stretch_sel = 3'd7; page_hit = !h; flat_mode = !f;
            end else if (inj != 0 && k == inj + 1) begin
                req = 1'b0;
            end
            if (done) begin
                m_len = k;
                break;
            end
            if (ale) m_ale++;
            if (addr_oe != ale) m_addr_mis++;
            if (!rd_n && !wr_n) m_both++;
            if (!rd_n) m_rd++;
            if (!wr_n) m_wr++;
            if (!rd_n || !wr_n) seen = 1;
            else if (!ale) begin
                if (seen) m_hold++;
                else m_setup++;
            end
            if (wdata_oe) m_woe++;
            @(negedge clk);
        end
        req = 1'b0;
        @(negedge clk);
        m_done2 = int'(done);
    endtask

    task automatic check_idle(input string tag);
        check(!ale && !addr_oe && !wdata_oe && rd_n && wr_n && !done, tag,
              "idle outputs (ale,addr_oe,wdata_oe,!rd_n,!wr_n,done all 0)",
              int'({ale, addr_oe, wdata_oe, !rd_n, !wr_n, done}), 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R9: outputs idle while reset is held
        repeat (3) @(negedge clk);
        check_idle("R9");
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            logic [20:0] v;
            int e_ale, e_set, e_str, e_hold, e_woe;
            bit w;
            v = VEC[i];
            w = v[15];
            e_ale = int'(v[14:12]); e_set = int'(v[11:8]);
            e_str = int'(v[7:3]);   e_hold = int'(v[2:0]);
            e_woe = w ? e_set + e_str + e_hold : 0;
            run_access(v[20:18], v[17], v[16], w, 0);
            // R3, R4: latch phase length depends on page hit and flat mode
            check(m_ale == e_ale && m_addr_mis == 0, v[16] ? "R4" : "R3",
                  $sformatf("ale clocks vec%0d", i), m_ale, e_ale);
            check(m_setup == e_set && m_hold == e_hold, "R2",
                  $sformatf("setup*100+hold vec%0d", i),
                  m_setup * 100 + m_hold, e_set * 100 + e_hold);
            check((w ? m_wr : m_rd) == e_str, "R1",
                  $sformatf("strobe clocks vec%0d", i), w ? m_wr : m_rd, e_str);
            check((w ? m_rd : m_wr) == 0 && m_both == 0, "R5",
                  $sformatf("wrong-strobe clocks vec%0d", i), (w ? m_rd : m_wr) + m_both, 0);
            check(m_woe == e_woe, "R6", $sformatf("wdata_oe clocks vec%0d", i), m_woe, e_woe);
            check(m_len == e_ale + e_set + e_str + e_hold + 1 && m_done2 == 0, "R8",
                  $sformatf("done clock vec%0d", i), m_len * 10 + m_done2,
                  (e_ale + e_set + e_str + e_hold + 1) * 10);
        end

        // R7: conflicting request during a running read is ignored
        run_access(3'd2, 1'b0, 1'b0, 1'b0, 3);
        check(m_ale == 2 && m_rd == 8 && m_wr == 0 && m_woe == 0, "R7",
              "ale*100+rd clocks, capture unchanged", m_ale * 100 + m_rd, 208);
        check(m_len == 15, "R7", "access length with mid-access request", m_len, 15);
        begin
            int act;
            act = 0;
            for (int k = 0; k < 8; k++) begin
                if (ale || !rd_n || !wr_n || wdata_oe) act++;
                @(negedge clk);
            end
            check(act == 0, "R7", "activity after ignored request", act, 0);
        end

        // R9: reset in the middle of a slow-group write
        @(negedge clk);
        stretch_sel = 3'd5; page_hit = 1'b0; flat_mode = 1'b0; req_write = 1'b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (10) @(negedge clk);
        check(wdata_oe == 1'b1, "R6", "wdata_oe during write setup", int'(wdata_oe), 1);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        begin
            int act;
            act = 0;
            for (int k = 0; k < 50; k++) begin
                if (done || !wr_n || !rd_n || wdata_oe || ale) act++;
                @(negedge clk);
            end
            check(act == 0, "R9", "activity after mid-access reset", act, 0);
        end

        // R8: a fresh access works right after the aborted one
        run_access(3'd1, 1'b1, 1'b0, 1'b1, 0);
        check(m_wr == 4 && m_len == 9, "R8", "wr*100+length after recovery",
              m_wr * 100 + m_len, 409);

        summary();
    end
endmodule